// File: doc/BRIEF.md
# Stream Identifier Range Filter Bank

This block decides, for each event counter of a performance monitor, whether a transaction carrying a given stream identifier should be counted. Every counter owns a filter slot. A slot holds a match value and a one-bit mode flag. In exact mode the slot accepts only an identifier that equals the match value. In span mode the match value carries its own wildcard width. The lowest clear bit of the match value is the boundary. That bit and every bit below it are ignored, and every bit above it must equal the identifier.

A match value of all ones in span mode has no clear bit, so it accepts every identifier. This is the slot's reset state, which means an unprogrammed counter counts every transaction. A global control makes slot 0 the filter for every counter. Software writes slots through a simple write strobe with a slot index. The qualify outputs are registered. A strobed identifier therefore produces its one-cycle qualify pulse on the following cycle.

Top module: `sid_span_filter`

## Requirements
- R1: After reset every `qualify` bit is 0, and every slot holds match value all ones with span mode (`span`=1). Such a slot qualifies any identifier.
- R2: With `span`=0, a slot qualifies an identifier only when the identifier equals the match value in all SID_W bits.
- R3: With `span`=1, let k be the position of the lowest 0 bit of the match value. Bits k down to 0 are ignored and bits above k must be equal. With match 0x42, identifiers 0x42 and 0x43 qualify and 0x40 and 0x44 do not. With match 0x3F, identifiers up to 0x7F qualify and 0x80 does not.
- R4: With `span`=1 and a match value of all ones, every identifier qualifies.
- R5: A cycle with `sid_valid`=0 produces no qualify bit in the next cycle, whatever `sid` holds.
- R6: An identifier sampled with `sid_valid`=1 at a rising edge sets `qualify` just after that edge. The bit lasts one cycle unless the next sample also qualifies.
- R7: With `glob_en`=1, bit i of `qualify` follows slot 0's match value and mode for every counter i. The bits of `qualify` are then either all 0 or all 1.
- R8: With `glob_en`=0, each bit i of `qualify` follows only slot i's own match value and mode.
- R9: A write with `cfg_we`=1 loads `cfg_match` and `cfg_span` into slot `cfg_idx` only. The other slots keep their contents. The new contents apply to identifiers sampled from the next rising edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | 1: slot 0 filters for all counters |
| cfg_we | input | 1 | Slot write strobe |
| cfg_idx | input | CTR_IDX_W | Slot index for the write |
| cfg_match | input | SID_W | Match value to load |
| cfg_span | input | 1 | Mode to load: 0 exact, 1 span |
| sid_valid | input | 1 | Identifier strobe |
| sid | input | SID_W | Transaction stream identifier |
| qualify | output | NUM_CTR | Per-counter count-enable, registered |

## Verification
The bench builds the block with its defaults: four slots and 32-bit identifiers. Four slots are enough to hold distinct configurations side by side. This shows that global mode overrides them and that a write to one index leaves its neighbours alone. Full 32-bit width brings the all-ones wrap case within reach, where incrementing the match value overflows to zero. It also allows boundaries both at bit 0 and at bit 6, with upper bits that must still compare.

// File: rtl/sidf_pkg.sv
package sidf_pkg;

    typedef enum logic {
        MODE_EXACT = 1'b0,
        MODE_SPAN  = 1'b1
    } span_mode_e;

endpackage

// File: rtl/sidf_mask_gen.sv
module sidf_mask_gen
    import sidf_pkg::*;
#(
    parameter int SID_W = 32
) (
    input  logic [SID_W-1:0] match_val,
    input  span_mode_e       mode,
    output logic [SID_W-1:0] cmp_mask
);
    logic [SID_W-1:0] inc_val;
    logic [SID_W-1:0] low_run;

    // Incrementing flips the trailing ones and the lowest zero. The XOR
    // marks exactly those positions. All ones wraps to zero, which leaves
    // an empty mask.
    always_comb begin
        inc_val = match_val + SID_W'(1);
        low_run = match_val ^ inc_val;
        unique case (mode)
            MODE_EXACT: cmp_mask = '1;
            MODE_SPAN:  cmp_mask = ~low_run;
            default:    cmp_mask = '1;
        endcase
    end
endmodule

// File: rtl/sidf_slot.sv
module sidf_slot
    import sidf_pkg::*;
#(
    parameter int SID_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SID_W-1:0] wr_match,
    input  logic             wr_span,
    input  logic [SID_W-1:0] sid,
    output logic [SID_W-1:0] match_o,
    output logic             span_o,
    output logic             hit_o
);
    logic [SID_W-1:0] match_q;
    span_mode_e       mode_q;
    logic [SID_W-1:0] mask;

    // Reset state is the pass-everything configuration.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '1;
            mode_q  <= MODE_SPAN;
        end else if (wr_en) begin
            match_q <= wr_match;
            mode_q  <= span_mode_e'(wr_span);
        end
    end

    sidf_mask_gen #(.SID_W(SID_W)) mask_i (
        .match_val (match_q),
        .mode      (mode_q),
        .cmp_mask  (mask)
    );

    always_comb begin
        hit_o   = ((sid ^ match_q) & mask) == '0;
        match_o = match_q;
        span_o  = (mode_q == MODE_SPAN);
    end
endmodule

// File: rtl/sid_span_filter.sv
module sid_span_filter
    import sidf_pkg::*;
#(
    parameter int NUM_CTR   = 4,
    parameter int SID_W     = 32,
    parameter int CTR_IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 glob_en,
    input  logic                 cfg_we,
    input  logic [CTR_IDX_W-1:0] cfg_idx,
    input  logic [SID_W-1:0]     cfg_match,
    input  logic                 cfg_span,
    input  logic                 sid_valid,
    input  logic [SID_W-1:0]     sid,
    output logic [NUM_CTR-1:0]   qualify
);
    logic [NUM_CTR-1:0][SID_W-1:0] slot_match;
    logic [NUM_CTR-1:0]            slot_span;
    logic [NUM_CTR-1:0]            slot_hit;
    logic [NUM_CTR-1:0]            slot_wr;
    logic [NUM_CTR-1:0]            eff_hit;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        always_comb slot_wr[i] = cfg_we && (cfg_idx == CTR_IDX_W'(i));

        sidf_slot #(.SID_W(SID_W)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (slot_wr[i]),
            .wr_match (cfg_match),
            .wr_span  (cfg_span),
            .sid      (sid),
            .match_o  (slot_match[i]),
            .span_o   (slot_span[i]),
            .hit_o    (slot_hit[i])
        );

        // Global mode routes slot 0's decision to every counter.
        always_comb eff_hit[i] = glob_en ? slot_hit[0] : slot_hit[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qualify <= '0;
        else        qualify <= sid_valid ? eff_hit : '0;
    end
endmodule

// File: rtl/sidf_checker.sv
module sidf_checker #(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               glob_en,
    input logic               sid_valid,
    input logic [SID_W-1:0]   sid,
    input logic [SID_W-1:0]   m0,
    input logic               s0,
    input logic [NUM_CTR-1:0] qualify
);
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sid_valid |=> qualify == '0);

    p_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sid_valid && !s0) |=> (qualify[0] == ($past(sid) == $past(m0))));

    p_self_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sid_valid && s0 && sid == m0) |=> qualify[0]);

    p_all_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sid_valid && s0 && m0 == '1) |=> qualify[0]);

    p_global_r7: assert property (@(posedge clk) disable iff (!rst_n)
        glob_en |=> (qualify == '0 || qualify == '1));
endmodule

bind sid_span_filter sidf_checker #(.NUM_CTR(NUM_CTR), .SID_W(SID_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_en   (glob_en),
    .sid_valid (sid_valid),
    .sid       (sid),
    .m0        (slot_match[0]),
    .s0        (slot_span[0]),
    .qualify   (qualify)
);

// File: tb/sid_span_filter_tb.sv
module sid_span_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int SW = 32;
    localparam int IW = 2;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          glob_en = 0;
    logic          cfg_we = 0;
    logic [IW-1:0] cfg_idx = '0;
    logic [SW-1:0] cfg_match = '0;
    logic          cfg_span = 0;
    logic          sid_valid = 0;
    logic [SW-1:0] sid = '0;
    logic [NC-1:0] qualify;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [SW-1:0] mdl_match [NC];
    logic          mdl_span  [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    sid_span_filter #(.NUM_CTR(NC), .SID_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_match(cfg_match), .cfg_span(cfg_span),
        .sid_valid(sid_valid), .sid(sid), .qualify(qualify)
    );

    // Reference: scan for the lowest zero bit, then compare the bits above it.
    function automatic bit ref_hit(logic [SW-1:0] m, logic sp, logic [SW-1:0] s);
        int k;
        if (!sp) return (s == m);
        k = -1;
        for (int b = SW - 1; b >= 0; b--) if (!m[b]) k = b;
        if (k < 0) return 1'b1;
        for (int b = k + 1; b < SW; b++) if (m[b] != s[b]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [NC-1:0] ref_vec(logic [SW-1:0] s);
        logic [NC-1:0] v;
        for (int i = 0; i < NC; i++) begin
            if (glob_en) v[i] = ref_hit(mdl_match[0], mdl_span[0], s);
            else         v[i] = ref_hit(mdl_match[i], mdl_span[i], s);
        end
        return v;
    endfunction

    task automatic check(string req, logic [NC-1:0] act, logic [NC-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: qualify=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic write_slot(int idx, logic [SW-1:0] m, logic sp);
        @(negedge clk);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_match = m; cfg_span = sp;
        @(negedge clk);
        cfg_we = 0;
        mdl_match[idx] = m;
        mdl_span[idx] = sp;
    endtask

    task automatic send(string req, logic [SW-1:0] s);
        logic [NC-1:0] exp;
        @(negedge clk);
        sid_valid = 1; sid = s;
        exp = ref_vec(s);
        @(negedge clk);
        sid_valid = 0;
        check(req, qualify, exp);
    endtask

    task automatic t_reset_r1;
        check("R1 reset", qualify, '0);
        send("R1 default pass", 32'hDEAD_BEEF);
    endtask

    task automatic t_exact_r2;
        write_slot(0, 32'h0000_0042, 0);
        send("R2 equal", 32'h0000_0042);
        send("R2 off by one", 32'h0000_0043);
        send("R2 high bit", 32'h8000_0042);
    endtask

    task automatic t_span_r3;
        write_slot(0, 32'h0000_0042, 1);
        send("R3 0x42", 32'h42);
        send("R3 0x43", 32'h43);
        send("R3 0x40", 32'h40);
        send("R3 0x44", 32'h44);
        write_slot(0, 32'h0000_003F, 1);
        send("R3 0x7F", 32'h7F);
        send("R3 0x00", 32'h00);
        send("R3 0x80", 32'h80);
    endtask

    task automatic t_ones_r4;
        write_slot(0, '1, 1);
        send("R4 zero", 32'h0);
        send("R4 top", 32'hFFFF_FFFF);
    endtask

    task automatic t_novalid_r5_r6;
        send("R6 pulse", 32'h1234);
        @(negedge clk);
        check("R6 one cycle", qualify, '0);
        sid = 32'h1234; sid_valid = 0;
        @(negedge clk);
        check("R5 no strobe", qualify, '0);
    endtask

    task automatic t_slots_r8_r9;
        write_slot(0, 32'h10, 0);
        write_slot(1, 32'h20, 0);
        write_slot(2, 32'h2F, 1);
        write_slot(3, 32'h30, 0);
        send("R8 slot1", 32'h20);
        send("R8 slot2 span", 32'h21);
        send("R8 slot3", 32'h30);
        write_slot(1, 32'h55, 0);
        send("R9 neighbours kept", 32'h30);
        send("R9 new value", 32'h55);
    endtask

    task automatic t_global_r7;
        glob_en = 1;
        send("R7 slot0 hit", 32'h10);
        send("R7 slot3 ignored", 32'h30);
        glob_en = 0;
        send("R7 back to per-slot", 32'h30);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) begin
            mdl_match[i] = '1;
            mdl_span[i] = 1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_r1();
        t_exact_r2();
        t_span_r3();
        t_ones_r4();
        t_novalid_r5_r6();
        t_slots_r8_r9();
        t_global_r7();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule